// File: doc/BRIEF.md
# Low-Power SDRAM Command Decoder

This block watches the command pins of a single-data-rate low-power SDRAM from the device side. At every rising clock edge it samples clock enable, the four command strobes, the data mask, the bank address and the address bus. From these it produces a one-hot command word, keeps copies of the two mode-register opcodes, and follows the device through its power states: idle or active, self refresh, self-refresh exit recovery, power-down, clock suspend and deep power-down. It also derives write-data and read-output enables from the data mask.

Each command is classified from the clock-enable level at the previous edge and at the current edge, together with the strobe pattern. On this device the strobe pattern that a standard SDRAM uses to stop a burst means deep power-down entry when clock enable falls. A command that is not allowed in the current state is dropped and flagged for one cycle. All outputs are registered, so the result for edge n is visible after edge n.

Top module: `lpsdr_cmd_decoder`

## Requirements
- R1: On a synchronous reset the state is idle (code 0), the command word and the error flag are zero, both opcode copies are zero and both data enables are low. The state codes are: 0 idle, 1 self refresh, 2 power-down, 3 clock suspend, 4 deep power-down, 5 exit recovery.
- R2: With clock enable high at both edges, the patterns {cs_n,ras_n,cas_n,we_n} decode as follows: 0111 or any pattern with cs_n high is NOP (bit 0), 0011 activate (bit 3), 0001 auto refresh (bit 11), 0110 burst stop (bit 10). The other bits are 1 mode set, 2 extended mode set, 4 read, 5 read with auto-precharge, 6 write, 7 write with auto-precharge, 8 precharge one bank, 9 precharge all, 12 self-refresh entry, 13 deep power-down entry, 14 power-down entry, 15 clock-suspend entry, 16 exit.
- R3: addr[10] high turns read (0101) and write (0100) into their auto-precharge forms, and turns precharge (0010) into precharge-all. When addr[10] is low, precharge acts on the addressed bank only.
- R4: Pattern 0000 with bank 0 is a mode set and with bank 1 an extended mode set. The whole address is stored into the matching opcode copy. Any other bank value raises the error flag and stores nothing.
- R5: When clock enable falls: 0110 enters deep power-down, 0001 enters self refresh, and any other pattern enters clock suspend if a burst is in progress or power-down if none is. A burst lasts BURST_LEN high-CKE idle edges after a read or write and is cancelled by burst stop. Entry with a pattern other than NOP is still performed, but the command is dropped and the error flag is raised.
- R6: In self refresh and in deep power-down, every pin except clock enable is ignored: no command bit and no error.
- R7: In power-down or clock suspend with clock enable held low, NOP is reported as NOP. Any other pattern raises the error flag, gives no command bit and leaves the state unchanged.
- R8: A clock-enable rise in any low-power state reports exit (bit 16). Power-down, clock suspend and deep power-down return to idle. Self refresh goes to exit recovery.
- R9: Exit recovery lasts at least TXSR_CYC edges after the exit edge, and continues until two NOPs have been seen with clock enable high. During recovery, any other pattern, or clock enable low, raises the error flag.
- R10: Leaving deep power-down clears both opcode copies. Reads and writes then raise the error flag until both a mode set and an extended mode set have been accepted.
- R11: After each edge the write-data enable equals the inverse of dqm sampled at that edge. The read-output enable equals the inverse of dqm sampled two edges earlier.
- R12: The error flag lasts one cycle per offending edge and is never raised together with a command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (11) | Address bus; bit 10 is the auto-precharge/all-banks bit |
| cmd_hot | output | 17 | One-hot decoded command |
| mr_op | output | ADDR_W | Mode register opcode copy |
| emr_op | output | ADDR_W | Extended mode register opcode copy |
| pwr_state | output | 3 | Current power state code |
| proto_err | output | 1 | Dropped-command flag |
| wr_data_en | output | 1 | Write data enable (mask latency 0) |
| rd_out_en | output | 1 | Read output enable (mask latency 2) |

## Verification
One ordered vector table walks the decoder through every strobe pattern with clock enable held high, falling, held low and rising, so the same pattern is tried in each power state. This separates burst stop from deep power-down entry, auto refresh from self-refresh entry, and power-down from clock suspend, which is settled by the burst counter one edge before it expires. The recovery window is run twice: once with clean NOPs, and once with rejected commands and a low clock-enable cycle, so that the cycle count and the NOP count are shown to be separate conditions. Directed sequences check the two mask latencies against an arbitrary mask pattern, and check that a reset taken in power-down wipes the state and the opcode copies.

// File: rtl/lpsdr_pkg.sv
// Shared types of the low-power SDRAM command decoder.
// Assumes: one-hot bit order of cmd_idx_e is part of the external contract.
package lpsdr_pkg;

    typedef enum logic [4:0] {
        CMD_NOP  = 5'd0,
        CMD_MRS  = 5'd1,
        CMD_EMRS = 5'd2,
        CMD_ACT  = 5'd3,
        CMD_RD   = 5'd4,
        CMD_RDA  = 5'd5,
        CMD_WR   = 5'd6,
        CMD_WRA  = 5'd7,
        CMD_PREB = 5'd8,
        CMD_PREA = 5'd9,
        CMD_BST  = 5'd10,
        CMD_AREF = 5'd11,
        CMD_SRE  = 5'd12,
        CMD_DPDE = 5'd13,
        CMD_PDE  = 5'd14,
        CMD_CSE  = 5'd15,
        CMD_EXIT = 5'd16
    } cmd_idx_e;

    localparam int NUM_CMDS = 17;

    typedef enum logic [2:0] {
        PS_IDLE = 3'd0,
        PS_SREF = 3'd1,
        PS_PDN  = 3'd2,
        PS_CSUS = 3'd3,
        PS_DPD  = 3'd4,
        PS_SRX  = 3'd5
    } pwr_e;

    typedef enum logic [2:0] {
        PAT_NOP,
        PAT_LMR,
        PAT_ACT,
        PAT_RD,
        PAT_WR,
        PAT_PRE,
        PAT_BST,
        PAT_REF
    } pat_e;

    typedef enum logic [1:0] {
        CK_HOLD_HI,
        CK_FALL,
        CK_RISE,
        CK_HOLD_LO
    } ck_e;

endpackage

// File: rtl/lpsdr_pin_decode.sv
// Pin-level classifier: maps the strobes to a pattern class and the
// clock-enable pair to an edge type. Purely combinational.
// Assumes: cs_n high means command inhibit, which is treated as NOP.
module lpsdr_pin_decode
    import lpsdr_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output pat_e pat,
    output ck_e  ck
);

    // Strobe pattern classification.
    always_comb begin
        if (cs_n) begin
            pat = PAT_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  pat = PAT_NOP;
                3'b000:  pat = PAT_LMR;
                3'b011:  pat = PAT_ACT;
                3'b101:  pat = PAT_RD;
                3'b100:  pat = PAT_WR;
                3'b010:  pat = PAT_PRE;
                3'b110:  pat = PAT_BST;
                default: pat = PAT_REF;
            endcase
        end
    end

    // Clock-enable transition between previous and current edge.
    always_comb begin
        case ({cke_prev, cke})
            2'b11:   ck = CK_HOLD_HI;
            2'b10:   ck = CK_FALL;
            2'b01:   ck = CK_RISE;
            default: ck = CK_HOLD_LO;
        endcase
    end

endmodule

// File: rtl/lpsdr_pwr_fsm.sv
// Power-state machine and command qualifier. It turns pattern and edge
// type into a registered one-hot command or a one-cycle error, tracks
// burst activity, exit recovery and the reprogramming need after deep
// power-down. Strobes for the opcode copies are combinational and take
// effect at the same edge as the command.
// Assumes: TXSR_CYC below 2 is raised to 2.
module lpsdr_pwr_fsm
    import lpsdr_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4,
    parameter int TXSR_CYC  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pat_e                pat,
    input  ck_e                 ck,
    input  logic [BA_W-1:0]     ba,
    input  logic                a10,
    output logic [NUM_CMDS-1:0] cmd_hot,
    output logic                proto_err,
    output pwr_e                state,
    output logic                mr_wr,
    output logic                emr_wr,
    output logic                op_clr
);

    localparam int REC = (TXSR_CYC < 2) ? 2 : TXSR_CYC;
    localparam int BW  = $clog2(BURST_LEN + 1);
    localparam int RW  = $clog2(REC + 1);

    pwr_e                state_q, state_n;
    logic [BW-1:0]       burst_q, burst_n;
    logic [RW-1:0]       rec_q, rec_n;
    logic [1:0]          nops_q, nops_n;
    logic [1:0]          need_q, need_n;
    logic [NUM_CMDS-1:0] cmd_q, cmd_n;
    logic                err_q, err_n;
    logic                hit;
    cmd_idx_e            idx;
    logic                burst_on;
    logic                cke_hi;
    logic [RW-1:0]       rec_dec;
    logic [1:0]          nops_new;

    assign burst_on = (burst_q != '0);
    assign cke_hi   = (ck == CK_HOLD_HI) || (ck == CK_RISE);

    // Next-state, command qualification and side effects.
    always_comb begin
        state_n  = state_q;
        burst_n  = burst_q;
        rec_n    = rec_q;
        nops_n   = nops_q;
        need_n   = need_q;
        err_n    = 1'b0;
        hit      = 1'b0;
        idx      = CMD_NOP;
        mr_wr    = 1'b0;
        emr_wr   = 1'b0;
        op_clr   = 1'b0;
        rec_dec  = (rec_q != '0) ? rec_q - 1'b1 : '0;
        nops_new = nops_q;
        case (state_q)
            PS_IDLE: begin
                if (ck == CK_FALL) begin
                    case (pat)
                        PAT_BST: begin
                            hit     = 1'b1;
                            idx     = CMD_DPDE;
                            state_n = PS_DPD;
                            burst_n = '0;
                        end
                        PAT_REF: begin
                            hit     = 1'b1;
                            idx     = CMD_SRE;
                            state_n = PS_SREF;
                            burst_n = '0;
                        end
                        default: begin
                            state_n = burst_on ? PS_CSUS : PS_PDN;
                            if (pat == PAT_NOP) begin
                                hit = 1'b1;
                                idx = burst_on ? CMD_CSE : CMD_PDE;
                            end else begin
                                err_n = 1'b1;
                            end
                        end
                    endcase
                end else begin
                    if (burst_on) begin
                        burst_n = burst_q - 1'b1;
                    end
                    case (pat)
                        PAT_NOP: begin
                            hit = 1'b1;
                            idx = CMD_NOP;
                        end
                        PAT_LMR: begin
                            if (ba == BA_W'(0)) begin
                                hit       = 1'b1;
                                idx       = CMD_MRS;
                                mr_wr     = 1'b1;
                                need_n[0] = 1'b0;
                            end else if (ba == BA_W'(1)) begin
                                hit       = 1'b1;
                                idx       = CMD_EMRS;
                                emr_wr    = 1'b1;
                                need_n[1] = 1'b0;
                            end else begin
                                err_n = 1'b1;
                            end
                        end
                        PAT_ACT: begin
                            hit = 1'b1;
                            idx = CMD_ACT;
                        end
                        PAT_RD, PAT_WR: begin
                            if (need_q != 2'b00) begin
                                err_n = 1'b1;
                            end else begin
                                hit     = 1'b1;
                                burst_n = BW'(BURST_LEN);
                                if (pat == PAT_RD) idx = a10 ? CMD_RDA : CMD_RD;
                                else               idx = a10 ? CMD_WRA : CMD_WR;
                            end
                        end
                        PAT_PRE: begin
                            hit = 1'b1;
                            idx = a10 ? CMD_PREA : CMD_PREB;
                        end
                        PAT_BST: begin
                            hit     = 1'b1;
                            idx     = CMD_BST;
                            burst_n = '0;
                        end
                        default: begin
                            hit = 1'b1;
                            idx = CMD_AREF;
                        end
                    endcase
                end
            end
            PS_SREF, PS_DPD: begin
                if (ck == CK_RISE) begin
                    hit = 1'b1;
                    idx = CMD_EXIT;
                    if (state_q == PS_SREF) begin
                        state_n = PS_SRX;
                        rec_n   = RW'(REC);
                        nops_n  = 2'd0;
                    end else begin
                        state_n = PS_IDLE;
                        need_n  = 2'b11;
                        op_clr  = 1'b1;
                    end
                end
            end
            PS_PDN, PS_CSUS: begin
                if (ck == CK_RISE) begin
                    hit     = 1'b1;
                    idx     = CMD_EXIT;
                    state_n = PS_IDLE;
                end else if (pat == PAT_NOP) begin
                    hit = 1'b1;
                    idx = CMD_NOP;
                end else begin
                    err_n = 1'b1;
                end
            end
            PS_SRX: begin
                if (cke_hi && pat == PAT_NOP) begin
                    hit      = 1'b1;
                    idx      = CMD_NOP;
                    nops_new = (nops_q == 2'd2) ? 2'd2 : nops_q + 2'd1;
                end else begin
                    err_n = 1'b1;
                end
                rec_n  = rec_dec;
                nops_n = nops_new;
                if (rec_dec == '0 && nops_new == 2'd2 && cke_hi) begin
                    state_n = PS_IDLE;
                end
            end
            default: state_n = PS_IDLE;
        endcase
        cmd_n = hit ? (NUM_CMDS'(1) << idx) : '0;
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            burst_q <= '0;
            rec_q   <= '0;
            nops_q  <= 2'd0;
            need_q  <= 2'b00;
            cmd_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            burst_q <= burst_n;
            rec_q   <= rec_n;
            nops_q  <= nops_n;
            need_q  <= need_n;
            cmd_q   <= cmd_n;
            err_q   <= err_n;
        end
    end

    assign cmd_hot   = cmd_q;
    assign proto_err = err_q;
    assign state     = state_q;

    // Checker counter: edges spent in exit recovery, saturating at REC.
    logic [RW-1:0] win_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                  win_q <= '0;
        else if (state_q != PS_SRX)                  win_q <= '0;
        else if (win_q != RW'(REC))                  win_q <= win_q + 1'b1;
    end

    p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_hot));

    p_err_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (cmd_hot == '0));

    p_rec_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && $past(state_q) == PS_SRX) |-> (win_q == RW'(REC)));

    p_sref_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SREF && $past(state_q) == PS_SREF) |-> (cmd_hot == '0 && !proto_err));

endmodule

// File: rtl/lpsdr_mode_regs.sv
// Holds the mode and extended-mode opcode copies. Written by strobes
// from the power-state machine; cleared on deep power-down exit.
// Assumes: write and clear strobes are never active together.
module lpsdr_mode_regs #(
    parameter int OP_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mr_wr,
    input  logic            emr_wr,
    input  logic            clr,
    input  logic [OP_W-1:0] opcode,
    output logic [OP_W-1:0] mr_q,
    output logic [OP_W-1:0] emr_q
);

    // Opcode capture and clearing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mr_q  <= '0;
            emr_q <= '0;
        end else begin
            if (mr_wr)  mr_q  <= opcode;
            if (emr_wr) emr_q <= opcode;
        end
    end

    p_excl_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mr_wr && emr_wr));

endmodule

// File: rtl/lpsdr_dqm_pipe.sv
// Data-mask timing: write enable follows the mask of the same edge,
// read output enable follows it RD_LAT edges later.
// Assumes: RD_LAT is at least 1.
module lpsdr_dqm_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    output logic wr_en,
    output logic rd_oe
);

    logic [RD_LAT:0] pipe_q;

    // Shift the inverted mask down the latency line.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[RD_LAT-1:0], ~dqm};
    end

    assign wr_en = pipe_q[0];
    assign rd_oe = pipe_q[RD_LAT];

    // Checker counter: edges since reset, saturating at 2.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    p_rd_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (rd_oe == $past(wr_en, 2)));

endmodule

// File: rtl/lpsdr_cmd_decoder.sv
// Top of the low-power SDRAM command decoder. Registers the previous
// clock-enable level, classifies pins, runs the power-state machine and
// keeps the opcode copies and mask timing.
// Assumes: pins are stable around the rising edge; addr[AP_BIT] is A10.
module lpsdr_cmd_decoder
    import lpsdr_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 11,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    parameter int TXSR_CYC  = 4,
    parameter int RD_LAT    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cke,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                dqm,
    input  logic [BA_W-1:0]     ba,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CMDS-1:0] cmd_hot,
    output logic [ADDR_W-1:0]   mr_op,
    output logic [ADDR_W-1:0]   emr_op,
    output logic [2:0]          pwr_state,
    output logic                proto_err,
    output logic                wr_data_en,
    output logic                rd_out_en
);

    logic cke_prev_q;
    pat_e pat;
    ck_e  ck;
    pwr_e state;
    logic mr_wr, emr_wr, op_clr;

    // Clock-enable level at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev_q <= 1'b1;
        else        cke_prev_q <= cke;
    end

    lpsdr_pin_decode i_pins (
        .cke_prev (cke_prev_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .pat      (pat),
        .ck       (ck)
    );

    lpsdr_pwr_fsm #(
        .BA_W      (BA_W),
        .BURST_LEN (BURST_LEN),
        .TXSR_CYC  (TXSR_CYC)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pat       (pat),
        .ck        (ck),
        .ba        (ba),
        .a10       (addr[AP_BIT]),
        .cmd_hot   (cmd_hot),
        .proto_err (proto_err),
        .state     (state),
        .mr_wr     (mr_wr),
        .emr_wr    (emr_wr),
        .op_clr    (op_clr)
    );

    lpsdr_mode_regs #(
        .OP_W (ADDR_W)
    ) i_mregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .mr_wr  (mr_wr),
        .emr_wr (emr_wr),
        .clr    (op_clr),
        .opcode (addr),
        .mr_q   (mr_op),
        .emr_q  (emr_op)
    );

    lpsdr_dqm_pipe #(
        .RD_LAT (RD_LAT)
    ) i_dqm (
        .clk   (clk),
        .rst_n (rst_n),
        .dqm   (dqm),
        .wr_en (wr_data_en),
        .rd_oe (rd_out_en)
    );

    assign pwr_state = state;

    p_idle_cke_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE) |-> cke_prev_q);

    p_dpd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_DPD && state == PS_IDLE) |-> (mr_op == '0 && emr_op == '0));

endmodule

// File: tb/test_lpsdr_cmd_decoder.sv
module test_lpsdr_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 50;

    typedef struct packed {
        logic [3:0]  req;
        logic        cke;
        logic [3:0]  pins;   // {cs_n, ras_n, cas_n, we_n}
        logic [1:0]  ba;
        logic [10:0] addr;
        logic [4:0]  ecmd;   // 31 = no command bit
        logic [2:0]  est;
        logic        ev;
        logic [10:0] emr;
        logic [10:0] eemr;
    } vec_t;

    // Walked in order; each row is one edge.
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h000, 11'h000}, // R2 NOP
        '{4'd2,  1'b1, 4'b1000, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h000, 11'h000}, // R2 inhibit
        '{4'd4,  1'b1, 4'b0000, 2'd0, 11'h123, 5'd1,  3'd0, 1'b0, 11'h123, 11'h000}, // R4 mode set
        '{4'd4,  1'b1, 4'b0000, 2'd1, 11'h2AB, 5'd2,  3'd0, 1'b0, 11'h123, 11'h2AB}, // R4 ext set
        '{4'd4,  1'b1, 4'b0000, 2'd2, 11'h7FF, 5'd31, 3'd0, 1'b1, 11'h123, 11'h2AB}, // R4 bad bank
        '{4'd2,  1'b1, 4'b0011, 2'd1, 11'h456, 5'd3,  3'd0, 1'b0, 11'h123, 11'h2AB}, // R2 activate
        '{4'd3,  1'b1, 4'b0101, 2'd0, 11'h010, 5'd4,  3'd0, 1'b0, 11'h123, 11'h2AB}, // R3 read
        '{4'd2,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h123, 11'h2AB},
        '{4'd5,  1'b0, 4'b0111, 2'd0, 11'h000, 5'd15, 3'd3, 1'b0, 11'h123, 11'h2AB}, // R5 suspend
        '{4'd7,  1'b0, 4'b0011, 2'd0, 11'h000, 5'd31, 3'd3, 1'b1, 11'h123, 11'h2AB}, // R7 R12
        '{4'd8,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd0, 1'b0, 11'h123, 11'h2AB}, // R8 exit
        '{4'd5,  1'b1, 4'b0110, 2'd0, 11'h000, 5'd10, 3'd0, 1'b0, 11'h123, 11'h2AB}, // R5 burst stop
        '{4'd5,  1'b0, 4'b0111, 2'd0, 11'h000, 5'd14, 3'd2, 1'b0, 11'h123, 11'h2AB}, // R5 power-down
        '{4'd8,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd0, 1'b0, 11'h123, 11'h2AB},
        '{4'd3,  1'b1, 4'b0100, 2'd0, 11'h400, 5'd7,  3'd0, 1'b0, 11'h123, 11'h2AB}, // R3 write AP
        '{4'd3,  1'b1, 4'b0010, 2'd0, 11'h400, 5'd9,  3'd0, 1'b0, 11'h123, 11'h2AB}, // R3 pre all
        '{4'd3,  1'b1, 4'b0010, 2'd3, 11'h000, 5'd8,  3'd0, 1'b0, 11'h123, 11'h2AB}, // R3 pre bank
        '{4'd2,  1'b1, 4'b0001, 2'd0, 11'h000, 5'd11, 3'd0, 1'b0, 11'h123, 11'h2AB}, // R2 refresh
        '{4'd5,  1'b0, 4'b0001, 2'd0, 11'h000, 5'd12, 3'd1, 1'b0, 11'h123, 11'h2AB}, // R5 sref
        '{4'd6,  1'b0, 4'b0011, 2'd0, 11'h000, 5'd31, 3'd1, 1'b0, 11'h123, 11'h2AB}, // R6 ignored
        '{4'd8,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd5, 1'b0, 11'h123, 11'h2AB}, // R8 to recovery
        '{4'd9,  1'b1, 4'b0011, 2'd0, 11'h000, 5'd31, 3'd5, 1'b1, 11'h123, 11'h2AB}, // R9
        '{4'd9,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd5, 1'b0, 11'h123, 11'h2AB},
        '{4'd9,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd5, 1'b0, 11'h123, 11'h2AB},
        '{4'd9,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h123, 11'h2AB},
        '{4'd5,  1'b0, 4'b0110, 2'd0, 11'h000, 5'd13, 3'd4, 1'b0, 11'h123, 11'h2AB}, // R5 deep pd
        '{4'd6,  1'b0, 4'b0000, 2'd0, 11'h111, 5'd31, 3'd4, 1'b0, 11'h123, 11'h2AB}, // R6
        '{4'd10, 1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd0, 1'b0, 11'h000, 11'h000}, // R10 cleared
        '{4'd10, 1'b1, 4'b0101, 2'd0, 11'h000, 5'd31, 3'd0, 1'b1, 11'h000, 11'h000},
        '{4'd10, 1'b1, 4'b0000, 2'd0, 11'h055, 5'd1,  3'd0, 1'b0, 11'h055, 11'h000},
        '{4'd10, 1'b1, 4'b0100, 2'd0, 11'h000, 5'd31, 3'd0, 1'b1, 11'h055, 11'h000},
        '{4'd10, 1'b1, 4'b0000, 2'd1, 11'h3C1, 5'd2,  3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd10, 1'b1, 4'b0100, 2'd0, 11'h000, 5'd6,  3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b0, 4'b0111, 2'd0, 11'h000, 5'd15, 3'd3, 1'b0, 11'h055, 11'h3C1}, // R5 last burst edge
        '{4'd8,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b0, 4'b0111, 2'd0, 11'h000, 5'd14, 3'd2, 1'b0, 11'h055, 11'h3C1}, // R5 burst done
        '{4'd7,  1'b0, 4'b0101, 2'd0, 11'h000, 5'd31, 3'd2, 1'b1, 11'h055, 11'h3C1}, // R7
        '{4'd8,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd0, 1'b0, 11'h055, 11'h3C1},
        '{4'd5,  1'b0, 4'b0001, 2'd0, 11'h000, 5'd12, 3'd1, 1'b0, 11'h055, 11'h3C1},
        '{4'd8,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd16, 3'd5, 1'b0, 11'h055, 11'h3C1},
        '{4'd9,  1'b1, 4'b0011, 2'd0, 11'h000, 5'd31, 3'd5, 1'b1, 11'h055, 11'h3C1}, // R9 rejected
        '{4'd9,  1'b1, 4'b0011, 2'd0, 11'h000, 5'd31, 3'd5, 1'b1, 11'h055, 11'h3C1},
        '{4'd9,  1'b1, 4'b0011, 2'd0, 11'h000, 5'd31, 3'd5, 1'b1, 11'h055, 11'h3C1},
        '{4'd9,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd5, 1'b0, 11'h055, 11'h3C1}, // R9 one NOP
        '{4'd9,  1'b0, 4'b0111, 2'd0, 11'h000, 5'd31, 3'd5, 1'b1, 11'h055, 11'h3C1}, // R9 cke low
        '{4'd9,  1'b1, 4'b0111, 2'd0, 11'h000, 5'd0,  3'd0, 1'b0, 11'h055, 11'h3C1}  // R9 leave
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [10:0] addr = 11'h000;
    logic [16:0] cmd_hot;
    logic [10:0] mr_op, emr_op;
    logic [2:0]  pwr_state;
    logic        proto_err, wr_data_en, rd_out_en;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpsdr_cmd_decoder i_lpsdr_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .addr(addr),
        .cmd_hot(cmd_hot), .mr_op(mr_op), .emr_op(emr_op), .pwr_state(pwr_state),
        .proto_err(proto_err), .wr_data_en(wr_data_en), .rd_out_en(rd_out_en)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic k, input logic [3:0] p, input logic [1:0] b,
                         input logic [10:0] a, input logic m);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b;
        addr = a;
        dqm = m;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic hist [8];
        logic [16:0] ehot;
        hist = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset, before any further edge
        check("R1", "state", 32'(pwr_state), 32'd0);
        check("R1", "cmd", 32'(cmd_hot), 32'd0);
        check("R1", "err", 32'(proto_err), 32'd0);
        check("R1", "mr", 32'(mr_op), 32'd0);
        check("R1", "emr", 32'(emr_op), 32'd0);
        check("R1", "wren", 32'(wr_data_en), 32'd0);
        check("R1", "rdoe", 32'(rd_out_en), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            drive(VECS[i].cke, VECS[i].pins, VECS[i].ba, VECS[i].addr, 1'b1);
            @(negedge clk);
            ehot = (VECS[i].ecmd == 5'd31) ? 17'd0 : (17'd1 << VECS[i].ecmd);
            check(tag, $sformatf("row%0d cmd", i), 32'(cmd_hot), 32'(ehot));
            check(tag, $sformatf("row%0d state", i), 32'(pwr_state), 32'(VECS[i].est));
            check(tag, $sformatf("row%0d err", i), 32'(proto_err), 32'(VECS[i].ev));
            check(tag, $sformatf("row%0d mr", i), 32'(mr_op), 32'(VECS[i].emr));
            check(tag, $sformatf("row%0d emr", i), 32'(emr_op), 32'(VECS[i].eemr));
        end

        // R11: mask latencies, write 0 edges, read 2 edges
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 4'b0111, 2'd0, 11'h000, hist[i]);
            @(negedge clk);
            check("R11", "wren", 32'(wr_data_en), 32'(!hist[i]));
            if (i >= 2) check("R11", "rdoe", 32'(rd_out_en), 32'(!hist[i-2]));
        end

        // R1: reset taken while in power-down
        drive(1'b0, 4'b0111, 2'd0, 11'h000, 1'b0);
        @(negedge clk);
        check("R5", "pd entry", 32'(pwr_state), 32'd2);
        drive(1'b1, 4'b0111, 2'd0, 11'h000, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "state after reset", 32'(pwr_state), 32'd0);
        check("R1", "mr after reset", 32'(mr_op), 32'd0);
        check("R1", "emr after reset", 32'(emr_op), 32'd0);
        check("R1", "wren after reset", 32'(wr_data_en), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule